// File: doc/BRIEF.md
# CAN Controller Interrupt and Command Register Block

This block holds the control-side registers of a CAN controller: the mode register, the extended and basic status registers, the two interrupt registers and the interrupt-enable register. It also decodes the write-only command register. A byte-wide register bus reads and writes these registers. The `ext_mode` input picks the extended register map when high and the basic map when low. The frame transmitter and the receive storage sit outside the block. They report to it through single-cycle event pulses (transmit finished, frame stored, overrun, receive storage emptied). The block drives one-cycle command pulses back to them (transmit request, buffer release, overrun clear) and produces one level-sensitive interrupt line.

A small state machine tracks the transmit handshake. It has two states. `TX_IDLE` means no frame is in flight. `TX_SEND` means a request has been issued and the block is waiting for the transmitter. The transition `TX_IDLE -> TX_SEND` happens when an accepted transmit command is written. The transition `TX_SEND -> TX_IDLE` happens on the transmit-finished pulse. Every register update takes effect on the clock edge after the bus access or event. The interrupt line is a combinational function of the registered state, so it is valid in that same following cycle. Read data is registered and appears in the cycle after the read strobe.

Register map, extended (`ext_mode`=1):
- 0: mode, low 5 bits; bit 0 = reset mode
- 1: command
- 2: status
- 3: interrupt
- 4: interrupt enable
- 16: first transmit byte

Register map, basic (`ext_mode`=0):
- 0: control, low 5 bits; bit 0 = reset mode; bits 4:1 enable interrupt bits 3:0
- 1: command
- 2: status
- 3: interrupt
- 10: first transmit byte

Status bits: 0 = receive buffer holds data, 1 = data overrun, 2 = transmit buffer free, 3 = transmit complete, 5 = transmitting.
Interrupt bits: 0 = receive, 1 = transmit, 3 = overrun.
Command bits: 0 = transmit, 2 = release receive buffer, 3 = clear overrun.

Top module: `can_irq_cmd`

## Requirements
- R1: After reset the block holds these values: mode 0x01, extended status 0x3C, basic control 0x01, basic status 0x0C, both interrupt registers 0x00 and interrupt enable 0x00. The interrupt line and all command pulses are low.
- R2: In extended mode `irq` is high exactly when (interrupt enable AND extended interrupt register) is non-zero. In basic mode `irq` is high exactly when (control bits 4:1 AND basic interrupt bits 3:0) is non-zero.
- R3: A read of address 3 returns the current interrupt register value and then clears the register. Interrupt bit 0 is set again at once if a received message is still pending.
- R4: Writing command bit 0 while `TX_IDLE` gives a one-cycle `tx_req` and clears status bits 2 and 3. While in `TX_SEND`, further transmit commands produce no pulse. The transmit-finished event then sets status bits 2 and 3, clears status bit 5 and sets interrupt bit 1.
- R5: Writing command bit 3 clears status bit 1 and interrupt bit 3, and gives a one-cycle `ovr_clear` pulse.
- R6: Writing command bit 2 gives a one-cycle `rx_release` pulse only when a received message is pending. Otherwise no pulse is produced.
- R7: In operating mode, a frame-stored event sets status bit 0 and interrupt bit 0 and marks a message pending. An overrun event sets status bit 1 and interrupt bit 3. In reset mode both events are ignored.
- R8: The receive-empty event clears the pending mark, status bit 0 and interrupt bit 0.
- R9: A write to the first transmit byte sets status bit 5 in operating mode and has no effect in reset mode.
- R10: The command address reads 0x00. The addresses from 4 (basic) or 5 (extended) up to 29 (basic) or 28 (extended) read 0x00. All other unmapped addresses read 0xFF.
- R11: In basic mode, writing a control value with bit 0 clear while bit 0 is already clear performs a software reset. The mode register loses bits 0x11 and gains bit 0. The extended status loses bits 0x37 and gains 0x34. The pending mark is cleared. The control register still takes the written value.
- R12: A mode (extended) or control (basic) write that takes bit 0 from 1 to 0 clears the pending mark.
- R13: Mode and control writes keep the low 5 bits of the written byte. Writes to the status and interrupt addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects the extended map, 0 the basic map |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_tx_done | input | 1 | Transmitter finished the frame |
| evt_rx_stored | input | 1 | Receive storage accepted a frame |
| evt_overrun | input | 1 | Receive storage overflowed |
| evt_rx_empty | input | 1 | Receive storage became empty |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | One-cycle transmit request |
| rx_release | output | 1 | One-cycle receive-buffer release |
| ovr_clear | output | 1 | One-cycle overrun clear |

## Verification
A pending mark that is wrongly kept or lost shows up on the second of two back-to-back interrupt reads. It also shows up in whether `rx_release` pulses. Both are visible one cycle after the access. A transmit state stuck in `TX_SEND` or `TX_IDLE` shows as a missing or repeated `tx_req`, or as wrong status bits 2, 3 and 5 on the next status read. A wrong interrupt register or enable shows on `irq` in the cycle right after the event that caused it, without any bus read.

// File: rtl/ccic_pkg.sv
package ccic_pkg;

    localparam int BYTE_W = 8;
    localparam int MODE_W = 5;

    // register offsets shared by both maps
    localparam int OFS_MODE   = 0;
    localparam int OFS_CMD    = 1;
    localparam int OFS_STAT   = 2;
    localparam int OFS_INT    = 3;
    localparam int OFS_IEN    = 4;

    // extended map windows
    localparam int EXT_TXB0     = 16;
    localparam int EXT_ZERO_LO  = 5;
    localparam int EXT_ZERO_HI  = 28;
    // basic map windows
    localparam int BAS_TXB0     = 10;
    localparam int BAS_ZERO_LO  = 4;
    localparam int BAS_ZERO_HI  = 29;

    // status bit positions
    localparam int SB_RXFULL = 0;
    localparam int SB_OVR    = 1;
    localparam int SB_TXFREE = 2;
    localparam int SB_TXDONE = 3;
    localparam int SB_TXING  = 5;

    // interrupt bit positions
    localparam int IB_RX  = 0;
    localparam int IB_TX  = 1;
    localparam int IB_OVR = 3;

    // command bit positions
    localparam int CB_TX   = 0;
    localparam int CB_REL  = 2;
    localparam int CB_CLRO = 3;

    // reset values
    localparam logic [MODE_W-1:0] MODE_RST  = 5'h01;
    localparam logic [MODE_W-1:0] CTRL_RST  = 5'h01;
    localparam logic [BYTE_W-1:0] STE_RST   = 8'h3C;
    localparam logic [BYTE_W-1:0] STB_RST   = 8'h0C;

    // software reset masks
    localparam logic [MODE_W-1:0] SWR_MODE_CLR = 5'h11;
    localparam logic [BYTE_W-1:0] SWR_STAT_CLR = 8'h37;
    localparam logic [BYTE_W-1:0] SWR_STAT_SET = 8'h34;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/ccic_tx_fsm.sv
module ccic_tx_fsm
    import ccic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_go,
    input  logic tx_done,
    output logic busy,
    output logic tx_finish
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        busy      = 1'b0;
        tx_finish = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (tx_go) state_d = TX_SEND;
            end
            TX_SEND: begin
                busy = 1'b1;
                if (tx_done) begin
                    tx_finish = 1'b1;
                    state_d   = TX_IDLE;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

endmodule

// File: rtl/ccic_cmd_decode.sv
module ccic_cmd_decode (
    input  logic wr_cmd,
    input  logic bit_tx,
    input  logic bit_rel,
    input  logic bit_clro,
    input  logic busy,
    input  logic pending,
    output logic tx_go,
    output logic rel_go,
    output logic clro_go
);

    always_comb begin
        tx_go   = wr_cmd && bit_tx && !busy;
        rel_go  = wr_cmd && bit_rel && pending;
        clro_go = wr_cmd && bit_clro;
    end

endmodule

// File: rtl/ccic_irq_gen.sv
module ccic_irq_gen
    import ccic_pkg::*;
#(
    parameter int BAS_W = 4
) (
    input  logic              ext_mode,
    input  logic [BYTE_W-1:0] ext_en,
    input  logic [BYTE_W-1:0] ext_ir,
    input  logic [BAS_W-1:0]  bas_en,
    input  logic [BAS_W-1:0]  bas_ir,
    output logic              irq
);

    logic [BYTE_W-1:0] hit_e;
    logic [BAS_W-1:0]  hit_b;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_ext
        assign hit_e[g] = ext_en[g] & ext_ir[g];
    end

    for (genvar g = 0; g < BAS_W; g++) begin : g_bas
        assign hit_b[g] = bas_en[g] & bas_ir[g];
    end

    assign irq = ext_mode ? (|hit_e) : (|hit_b);

endmodule

// File: rtl/can_irq_cmd.sv
module can_irq_cmd
    import ccic_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              evt_tx_done,
    input  logic              evt_rx_stored,
    input  logic              evt_overrun,
    input  logic              evt_rx_empty,
    output logic              irq,
    output logic              tx_req,
    output logic              rx_release,
    output logic              ovr_clear
);

    localparam int BAS_IW = MODE_W - 1;

    logic [MODE_W-1:0] mode_q, mode_d, ctrl_q, ctrl_d;
    logic [BYTE_W-1:0] sts_e_q, sts_e_d, sts_b_q, sts_b_d;
    logic [BYTE_W-1:0] ir_e_q, ir_e_d, ir_b_q, ir_b_d;
    logic [BYTE_W-1:0] ier_q, ier_d;
    logic              pend_q, pend_d;
    logic [BYTE_W-1:0] rdata_q, rd_mux;
    logic              tx_req_q, rel_q, clro_q;

    logic [BYTE_W-1:0] act_sts, act_ir;
    logic              oper, sw_rst;
    logic              tx_go, rel_go, clro_go, busy, tx_finish;
    logic              hit_mode, hit_cmd, hit_ien, hit_txb, rd_int;
    int unsigned       a_idx;

    assign a_idx    = 32'(bus_addr);
    assign hit_mode = (a_idx == OFS_MODE);
    assign hit_cmd  = (a_idx == OFS_CMD);
    assign hit_ien  = (a_idx == OFS_IEN) && ext_mode;
    assign hit_txb  = ext_mode ? (a_idx == EXT_TXB0) : (a_idx == BAS_TXB0);
    assign rd_int   = bus_rd && (a_idx == OFS_INT);

    ccic_cmd_decode u_dec (
        .wr_cmd   (bus_wr && hit_cmd),
        .bit_tx   (bus_wdata[CB_TX]),
        .bit_rel  (bus_wdata[CB_REL]),
        .bit_clro (bus_wdata[CB_CLRO]),
        .busy     (busy),
        .pending  (pend_q),
        .tx_go    (tx_go),
        .rel_go   (rel_go),
        .clro_go  (clro_go)
    );

    ccic_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_go     (tx_go),
        .tx_done   (evt_tx_done),
        .busy      (busy),
        .tx_finish (tx_finish)
    );

    ccic_irq_gen #(.BAS_W(BAS_IW)) u_irq (
        .ext_mode (ext_mode),
        .ext_en   (ier_q),
        .ext_ir   (ir_e_q),
        .bas_en   (ctrl_q[MODE_W-1:1]),
        .bas_ir   (ir_b_q[BAS_IW-1:0]),
        .irq      (irq)
    );

    // next-state of all registers; later statements take priority
    always_comb begin
        mode_d  = mode_q;
        ctrl_d  = ctrl_q;
        ier_d   = ier_q;
        sts_e_d = sts_e_q;
        sts_b_d = sts_b_q;
        ir_e_d  = ir_e_q;
        ir_b_d  = ir_b_q;
        pend_d  = pend_q;
        sw_rst  = 1'b0;
        act_sts = ext_mode ? sts_e_q : sts_b_q;
        act_ir  = ext_mode ? ir_e_q  : ir_b_q;
        oper    = ext_mode ? !mode_q[0] : !ctrl_q[0];

        // read-to-clear, receive bit re-armed while a message waits
        if (rd_int) act_ir = {{(BYTE_W-1){1'b0}}, pend_q};

        if (bus_wr && hit_mode) begin
            if (ext_mode) begin
                mode_d = bus_wdata[MODE_W-1:0];
                if (mode_q[0] && !bus_wdata[0]) pend_d = 1'b0;
            end else begin
                ctrl_d = bus_wdata[MODE_W-1:0];
                if (ctrl_q[0] && !bus_wdata[0])       pend_d = 1'b0;
                else if (!ctrl_q[0] && !bus_wdata[0]) sw_rst = 1'b1;
            end
        end

        if (bus_wr && hit_ien) ier_d = bus_wdata;

        if (bus_wr && hit_txb && oper) act_sts[SB_TXING] = 1'b1;

        if (tx_go) begin
            act_sts[SB_TXFREE] = 1'b0;
            act_sts[SB_TXDONE] = 1'b0;
        end

        if (clro_go) begin
            act_sts[SB_OVR] = 1'b0;
            act_ir[IB_OVR]  = 1'b0;
        end

        if (tx_finish) begin
            act_sts[SB_TXFREE] = 1'b1;
            act_sts[SB_TXDONE] = 1'b1;
            act_sts[SB_TXING]  = 1'b0;
            act_ir[IB_TX]      = 1'b1;
        end

        if (evt_rx_stored && oper) begin
            pend_d             = 1'b1;
            act_sts[SB_RXFULL] = 1'b1;
            act_ir[IB_RX]      = 1'b1;
        end

        if (evt_overrun && oper) begin
            act_sts[SB_OVR] = 1'b1;
            act_ir[IB_OVR]  = 1'b1;
        end

        if (evt_rx_empty) begin
            pend_d             = 1'b0;
            act_sts[SB_RXFULL] = 1'b0;
            act_ir[IB_RX]      = 1'b0;
        end

        if (ext_mode) begin
            sts_e_d = act_sts;
            ir_e_d  = act_ir;
        end else begin
            sts_b_d = act_sts;
            ir_b_d  = act_ir;
        end

        if (sw_rst) begin
            mode_d  = (mode_q & ~SWR_MODE_CLR) | MODE_RST;
            sts_e_d = (sts_e_q & ~SWR_STAT_CLR) | SWR_STAT_SET;
            pend_d  = 1'b0;
        end
    end

    // read multiplexer
    always_comb begin
        rd_mux = 8'hFF;
        if (a_idx == OFS_MODE)      rd_mux = ext_mode ? BYTE_W'(mode_q) : BYTE_W'(ctrl_q);
        else if (a_idx == OFS_CMD)  rd_mux = 8'h00;
        else if (a_idx == OFS_STAT) rd_mux = ext_mode ? sts_e_q : sts_b_q;
        else if (a_idx == OFS_INT)  rd_mux = ext_mode ? ir_e_q : ir_b_q;
        else if (ext_mode) begin
            if (a_idx == OFS_IEN) rd_mux = ier_q;
            else if (a_idx >= EXT_ZERO_LO && a_idx <= EXT_ZERO_HI) rd_mux = 8'h00;
        end else begin
            if (a_idx >= BAS_ZERO_LO && a_idx <= BAS_ZERO_HI) rd_mux = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_RST;
            ctrl_q   <= CTRL_RST;
            ier_q    <= '0;
            sts_e_q  <= STE_RST;
            sts_b_q  <= STB_RST;
            ir_e_q   <= '0;
            ir_b_q   <= '0;
            pend_q   <= 1'b0;
            rdata_q  <= '0;
            tx_req_q <= 1'b0;
            rel_q    <= 1'b0;
            clro_q   <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            ctrl_q   <= ctrl_d;
            ier_q    <= ier_d;
            sts_e_q  <= sts_e_d;
            sts_b_q  <= sts_b_d;
            ir_e_q   <= ir_e_d;
            ir_b_q   <= ir_b_d;
            pend_q   <= pend_d;
            if (bus_rd) rdata_q <= rd_mux;
            tx_req_q <= tx_go;
            rel_q    <= rel_go;
            clro_q   <= clro_go;
        end
    end

    assign bus_rdata  = rdata_q;
    assign tx_req     = tx_req_q;
    assign rx_release = rel_q;
    assign ovr_clear  = clro_q;

endmodule

// File: rtl/ccic_chk.sv
module ccic_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_mode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic              evt_rx_empty,
    input logic              irq,
    input logic              tx_req,
    input logic              rx_release,
    input logic              ovr_clear,
    input logic              pend_q,
    input logic [7:0]        ir_e_q,
    input logic [7:0]        ier_q
);

    assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && ier_q == 8'h00) |-> !irq);

    assert_rx_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && bus_rd && !bus_wr && 32'(bus_addr) == 3 && pend_q && !evt_rx_empty)
        |=> ir_e_q[0]);

    assert_tx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    assert_clear_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && 32'(bus_addr) == 1 && bus_wdata[3]) |=> ovr_clear);

    assert_no_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && 32'(bus_addr) == 1 && bus_wdata[2] && !pend_q) |=> !rx_release);

endmodule

bind can_irq_cmd ccic_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_mode     (ext_mode),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .evt_rx_empty (evt_rx_empty),
    .irq          (irq),
    .tx_req       (tx_req),
    .rx_release   (rx_release),
    .ovr_clear    (ovr_clear),
    .pend_q       (pend_q),
    .ir_e_q       (ir_e_q),
    .ier_q        (ier_q)
);

// File: tb/sim_can_irq_cmd.sv
module sim_can_irq_cmd;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b1;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_tx_done = 1'b0, evt_rx_stored = 1'b0;
    logic       evt_overrun = 1'b0, evt_rx_empty = 1'b0;
    logic       irq, tx_req, rx_release, ovr_clear;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    can_irq_cmd u0 (.*);

    // vector: op[29:28] addr[27:23] data[22:15] exp[14:7] chk_rd[6] chk_irq[5] exp_irq[4] req[3:0]
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;
    // event data bits: 0 tx_done, 1 rx_stored, 2 overrun, 3 rx_empty
    localparam int NV = 35;
    localparam logic [29:0] VEC [NV] = '{
        {OP_RD, 5'd2,  8'h00, 8'h3C, 1'b1, 1'b1, 1'b0, 4'd1},   // R1 status
        {OP_RD, 5'd0,  8'h00, 8'h01, 1'b1, 1'b1, 1'b0, 4'd1},   // R1 mode
        {OP_RD, 5'd4,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd1},   // R1 enable
        {OP_WR, 5'd4,  8'h0B, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2},   // R2 enable write
        {OP_EV, 5'd0,  8'h02, 8'h00, 1'b0, 1'b1, 1'b0, 4'd7},   // R7 ignored in reset
        {OP_RD, 5'd3,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 4'd7},   // R7
        {OP_WR, 5'd0,  8'h08, 8'h00, 1'b0, 1'b0, 1'b0, 4'd13},  // R13 leave reset
        {OP_RD, 5'd0,  8'h00, 8'h08, 1'b1, 1'b0, 1'b0, 4'd13},  // R13
        {OP_EV, 5'd0,  8'h02, 8'h00, 1'b0, 1'b1, 1'b1, 4'd2},   // R2 rx raises irq
        {OP_RD, 5'd2,  8'h00, 8'h3D, 1'b1, 1'b1, 1'b1, 4'd7},   // R7 status bit0
        {OP_RD, 5'd3,  8'h00, 8'h01, 1'b1, 1'b1, 1'b1, 4'd3},   // R3 read, rearm
        {OP_RD, 5'd3,  8'h00, 8'h01, 1'b1, 1'b1, 1'b1, 4'd3},   // R3 rearmed
        {OP_EV, 5'd0,  8'h08, 8'h00, 1'b0, 1'b1, 1'b0, 4'd8},   // R8 empty
        {OP_RD, 5'd3,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 4'd8},   // R8
        {OP_RD, 5'd2,  8'h00, 8'h3C, 1'b1, 1'b0, 1'b0, 4'd8},   // R8
        {OP_WR, 5'd1,  8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 4'd4},   // R4 transmit
        {OP_RD, 5'd2,  8'h00, 8'h30, 1'b1, 1'b0, 1'b0, 4'd4},   // R4 bits 2,3 clear
        {OP_EV, 5'd0,  8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 4'd4},   // R4 done -> irq
        {OP_RD, 5'd2,  8'h00, 8'h1C, 1'b1, 1'b0, 1'b0, 4'd4},   // R4 final status
        {OP_RD, 5'd3,  8'h00, 8'h02, 1'b1, 1'b1, 1'b0, 4'd3},   // R3 clears tx bit
        {OP_EV, 5'd0,  8'h04, 8'h00, 1'b0, 1'b1, 1'b1, 4'd7},   // R7 overrun
        {OP_RD, 5'd2,  8'h00, 8'h1E, 1'b1, 1'b1, 1'b1, 4'd7},   // R7
        {OP_WR, 5'd1,  8'h08, 8'h00, 1'b0, 1'b1, 1'b0, 4'd5},   // R5 clear overrun
        {OP_RD, 5'd2,  8'h00, 8'h1C, 1'b1, 1'b0, 1'b0, 4'd5},   // R5
        {OP_RD, 5'd3,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd5},   // R5
        {OP_WR, 5'd16, 8'h55, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9},   // R9 tx byte
        {OP_RD, 5'd2,  8'h00, 8'h3C, 1'b1, 1'b0, 1'b0, 4'd9},   // R9
        {OP_RD, 5'd1,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd10},  // R10 command
        {OP_RD, 5'd7,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 4'd10},  // R10 reserved
        {OP_RD, 5'd30, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd10},  // R10 unmapped
        {OP_WR, 5'd2,  8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd13},  // R13 status write
        {OP_RD, 5'd2,  8'h00, 8'h3C, 1'b1, 1'b0, 1'b0, 4'd13},  // R13
        {OP_WR, 5'd3,  8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 4'd13},  // R13 int write
        {OP_RD, 5'd3,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 4'd13},  // R13
        {OP_RD, 5'd31, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd10}   // R10 unmapped
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // every operation: drive at a falling edge, release and sample at the next
    task automatic op(input logic [1:0] kind, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = (kind == OP_WR);
        bus_rd = (kind == OP_RD);
        if (kind == OP_EV) begin
            evt_tx_done   = d[0];
            evt_rx_stored = d[1];
            evt_overrun   = d[2];
            evt_rx_empty  = d[3];
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        evt_tx_done = 1'b0; evt_rx_stored = 1'b0;
        evt_overrun = 1'b0; evt_rx_empty = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        hw_reset();
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 pulses", {5'd0, tx_req, rx_release, ovr_clear}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][29:28], VEC[i][27:23], VEC[i][22:15]);
            if (VEC[i][6])
                check($sformatf("R%0d vec%0d data", VEC[i][3:0], i), bus_rdata, VEC[i][14:7]);
            if (VEC[i][5])
                check($sformatf("R%0d vec%0d irq", VEC[i][3:0], i), {7'd0, irq}, {7'd0, VEC[i][4]});
        end

        // R1 basic map reset values
        hw_reset();
        ext_mode = 1'b0;
        op(OP_RD, 5'd2, 8'h00); check("R1 basic status", bus_rdata, 8'h0C);
        op(OP_RD, 5'd0, 8'h00); check("R1 control", bus_rdata, 8'h01);
        op(OP_RD, 5'd3, 8'h00); check("R1 basic int", bus_rdata, 8'h00);

        // R2 basic enables come from control bits 4:1
        op(OP_WR, 5'd0, 8'h02);
        op(OP_EV, 5'd0, 8'h04); check("R2 overrun masked", {7'd0, irq}, 8'h00);
        op(OP_EV, 5'd0, 8'h02); check("R2 rx enabled", {7'd0, irq}, 8'h01);

        // R6 release pulses only while pending
        op(OP_WR, 5'd1, 8'h04); check("R6 release pending", {7'd0, rx_release}, 8'h01);
        op(OP_EV, 5'd0, 8'h08); check("R8 basic empty irq", {7'd0, irq}, 8'h00);
        op(OP_WR, 5'd1, 8'h04); check("R6 release idle", {7'd0, rx_release}, 8'h00);

        // R4 single pulse, second request ignored while sending
        ext_mode = 1'b1;
        op(OP_WR, 5'd0, 8'h1E);
        op(OP_WR, 5'd1, 8'h01); check("R4 tx pulse", {7'd0, tx_req}, 8'h01);
        op(OP_WR, 5'd1, 8'h01); check("R4 busy no pulse", {7'd0, tx_req}, 8'h00);
        op(OP_WR, 5'd1, 8'h08); check("R5 pulse", {7'd0, ovr_clear}, 8'h01);

        // R11 software reset from basic mode
        ext_mode = 1'b0;
        op(OP_EV, 5'd0, 8'h02);
        op(OP_WR, 5'd0, 8'h12);
        op(OP_RD, 5'd3, 8'h00); check("R11 int before", bus_rdata, 8'h09);
        op(OP_RD, 5'd3, 8'h00); check("R11 counters zeroed", bus_rdata, 8'h00);
        op(OP_RD, 5'd0, 8'h00); check("R11 control kept", bus_rdata, 8'h12);
        ext_mode = 1'b1;
        op(OP_RD, 5'd0, 8'h00); check("R11 mode", bus_rdata, 8'h0F);
        op(OP_RD, 5'd2, 8'h00); check("R11 ext status", bus_rdata, 8'h34);

        // R12 leaving reset mode drops the pending mark
        op(OP_WR, 5'd0, 8'h00);
        op(OP_EV, 5'd0, 8'h02);
        op(OP_WR, 5'd0, 8'h01);
        op(OP_WR, 5'd0, 8'h00);
        op(OP_RD, 5'd3, 8'h00); check("R12 first read", bus_rdata, 8'h01);
        op(OP_RD, 5'd3, 8'h00); check("R12 no rearm", bus_rdata, 8'h00);

        // R9 transmit byte write in reset mode has no effect
        op(OP_EV, 5'd0, 8'h01);
        op(OP_WR, 5'd0, 8'h01);
        op(OP_WR, 5'd16, 8'hAA);
        op(OP_RD, 5'd2, 8'h00); check("R9 reset mode", bus_rdata, 8'h1D);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule